// File: doc/BRIEF.md
# Timer Tick Source Selector and Prescaler

This block makes the counting tick for a general-purpose timer counter. A 3-bit slave-mode code decides where the count events come from. They come either from the internal clock, with one event every cycle, or from an external trigger source. When the source is external, a 3-bit trigger-select code picks one of four internal trigger inputs, a channel-0 edge signal or a filtered external trigger. The chosen source passes through a two-flop synchronizer, and each rising edge of it becomes one single-cycle event.

The events feed a prescaler that divides by the active prescale value plus one. The active value is reloaded from the programmed value only when an update event arrives. A counter-enable input gates the prescaler. When the prescaler wraps, the block emits one tick pulse. The downstream counter advances by one on each tick.

Top module: `tick_source_sel`

## Requirements
- R1: During reset and after its release, `tick` is low and the prescaler count is zero. With enable set, internal source and an active value N loaded, the first tick comes out on the (N+1)-th rising clock edge after enable is raised.
- R2: Slave-mode code 0 selects the internal clock: with enable set, `tick` is high once every N+1 cycles, where N is the active prescale value.
- R3: Slave-mode codes 4, 5 and 6 also select the internal clock and give the same tick rate as code 0.
- R4: Slave-mode codes 1, 2, 3 and 7 select an external source through `trig_sel`, with this mapping:
  - 0 to 3 select `itrig[0]` to `itrig[3]`.
  - 4 selects `ch0_edge`.
  - 7 selects `ext_trig_f`.
  - 5 and 6 select no source, so no events occur.
- R5: In an external mode, each rising edge of the selected source gives exactly one prescaler event. The source is sampled into two synchronizer flops, so the resulting tick, when it occurs, is high after the third rising clock edge that sees the source high.
- R6: An active prescale value of 0 passes every event through, giving one tick per event.
- R7: A new `psc_val` has no effect until a cycle with `update` high loads it into the active divider. The divider keeps its value at all other times.
- R8: While `cnt_en` is low, the prescaler count is held at zero and `tick` stays low.
- R9: `tick` is a single-cycle pulse. It can be high in two consecutive cycles only when the active prescale value is 0.
- R10: In the internal-clock modes, `trig_sel` and all trigger inputs have no effect on `tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Counter enable; gates the prescaler |
| slave_mode | input | 3 | Slave-mode code |
| trig_sel | input | 3 | Trigger-source select |
| itrig | input | 4 | Internal trigger inputs |
| ch0_edge | input | 1 | Channel-0 input edge signal |
| ext_trig_f | input | 1 | Filtered external trigger |
| psc_val | input | PSC_W | Programmed (shadow) prescale value |
| update | input | 1 | Update event; loads `psc_val` into the active divider |
| tick | output | 1 | Single-cycle counting tick |

## Verification
The only visible output is the tick stream, so any wrong internal state shows up as a misplaced or missing tick.

- **Stuck or miscounting prescaler:** the tick moves by at least one cycle within one division period.
- **Wrong source decode:** ticks come at the clock rate when edge-driven ticks are expected, or the other way round. This shows within a few cycles of the mode being set.
- **Synchronizer or edge-detector fault:** extra or missing ticks appear on the next trigger edge.
- **Shadow value loaded early:** the division period changes before the update event.

A cycle-accurate model compares `tick` on every clock, so the first cycle that differs is reported.

// File: rtl/tick_source_sel.sv
module tick_source_sel #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [2:0]       slave_mode,
  input  logic [2:0]       trig_sel,
  input  logic [3:0]       itrig,
  input  logic             ch0_edge,
  input  logic             ext_trig_f,
  input  logic [PSC_W-1:0] psc_val,
  input  logic             update,
  output logic             tick
);
  localparam logic [2:0] SEL_CH0 = 3'd4;
  localparam logic [2:0] SEL_ETF = 3'd7;

  logic             ext_mode, trig_raw, edge_pulse, in_evt, wrap;
  logic [1:0]       sync_q;
  logic             prev_q, tick_q;
  logic [PSC_W-1:0] div_q, cnt_q;

  assign ext_mode = (slave_mode == 3'd1) || (slave_mode == 3'd2) ||
                    (slave_mode == 3'd3) || (slave_mode == 3'd7);

  always_comb begin
    if (trig_sel[2] == 1'b0)    trig_raw = itrig[trig_sel[1:0]];
    else if (trig_sel == SEL_CH0) trig_raw = ch0_edge;
    else if (trig_sel == SEL_ETF) trig_raw = ext_trig_f;
    else                          trig_raw = 1'b0;
  end

  assign edge_pulse = sync_q[1] & ~prev_q;
  assign in_evt     = ext_mode ? edge_pulse : 1'b1;
  assign wrap       = (cnt_q >= div_q);
  assign tick       = tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      div_q  <= '0;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], trig_raw};
      prev_q <= sync_q[1];
      if (update) div_q <= psc_val;
      if (!cnt_en)     cnt_q <= '0;
      else if (in_evt) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      tick_q <= cnt_en & in_evt & wrap;
    end
  end

  AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(cnt_en));                                   // R8
  AST_CNT_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> (cnt_q == '0));                                // R8
  AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> $stable(div_q));                               // R7
  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_pulse |=> !edge_pulse);                               // R5
  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $past(tick)) |-> ($past(div_q) == '0));           // R9
endmodule

// File: tb/test_tick_source_sel.sv
module test_tick_source_sel;
  logic clk = 1'b0, rst_n = 1'b0, cnt_en = 1'b0, ch0_edge = 1'b0, ext_trig_f = 1'b0, update = 1'b0;
  logic [2:0]  slave_mode = '0, trig_sel = '0;
  logic [3:0]  itrig = '0;
  logic [15:0] psc_val = '0;
  logic        tick;

  int total = 0, bad = 0, win = 0, consec = 0;
  bit last_tick = 0, done = 0;
  string cur_req = "R1";

  int m_s1 = 0, m_s2 = 0, m_prv = 0, m_cnt = 0, m_div = 0, m_tick = 0;

  tick_source_sel i_tick_source_sel (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .slave_mode(slave_mode),
    .trig_sel(trig_sel), .itrig(itrig), .ch0_edge(ch0_edge), .ext_trig_f(ext_trig_f),
    .psc_val(psc_val), .update(update), .tick(tick));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    int raw, evt, ext, nt;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prv = 0; m_cnt = 0; m_div = 0; m_tick = 0;
    end else begin
      ext = (slave_mode inside {3'd1, 3'd2, 3'd3, 3'd7});
      case (trig_sel)
        3'd0, 3'd1, 3'd2, 3'd3: raw = itrig[trig_sel];
        3'd4: raw = ch0_edge;
        3'd7: raw = ext_trig_f;
        default: raw = 0;
      endcase
      evt = ext ? (m_s2 && !m_prv) : 1;
      nt = (cnt_en && evt && m_cnt >= m_div);
      if (!cnt_en) m_cnt = 0;
      else if (evt) m_cnt = (m_cnt >= m_div) ? 0 : m_cnt + 1;
      if (update) m_div = psc_val;
      m_tick = nt;
      m_prv = m_s2; m_s2 = m_s1; m_s1 = raw;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check(tick === m_tick[0], cur_req, tick, m_tick);
    if (tick) win++;
    if (tick && last_tick) consec++;
    last_tick = tick;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic cfg(logic [2:0] m, logic [2:0] s, int p);
    cnt_en = 0; step();
    slave_mode = m; trig_sel = s; psc_val = 16'(p); update = 1; step();
    update = 0; cnt_en = 1; win = 0; consec = 0;
  endtask

  task automatic pulses(int which, int n);
    for (int i = 0; i < n; i++) begin
      case (which)
        0: itrig[2] = 1; 1: ext_trig_f = 1; 2: ch0_edge = 1; default: begin itrig = '1; ch0_edge = 1; ext_trig_f = 1; end
      endcase
      run(2);
      itrig = '0; ch0_edge = 0; ext_trig_f = 0;
      run(2);
    end
    run(6);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    run(3);
    check(tick === 1'b0, "R1 reset", tick, 0);
    rst_n = 1; run(3);
    check(tick === 1'b0, "R1 after reset", tick, 0);

    cur_req = "R2"; cfg(3'd0, 3'd0, 3);
    run(3); check(win == 0, "R1 first tick not early", win, 0);
    run(1); check(win == 1, "R1 first tick on 4th edge", win, 1);
    run(36); check(win == 10, "R2 mode0 div4", win, 10);

    cur_req = "R3"; cfg(3'd5, 3'd2, 3);
    for (int i = 0; i < 40; i++) begin itrig = 4'(i); step(); end
    itrig = '0;
    check(win == 10, "R3 R10 mode5 internal", win, 10);
    cur_req = "R3"; cfg(3'd6, 3'd7, 1);
    for (int i = 0; i < 20; i++) begin ext_trig_f = i[0]; step(); end
    ext_trig_f = 0;
    check(win == 10, "R3 R10 mode6 internal", win, 10);

    cur_req = "R4"; cfg(3'd1, 3'd2, 0);
    run(4); win = 0; consec = 0;
    for (int i = 0; i < 5; i++) begin
      itrig[2] = 1; itrig[0] = 1; run(1); itrig[0] = 0; run(1);
      itrig[2] = 0; itrig[1] = 1; run(1); itrig[1] = 0; run(1);
    end
    run(6);
    check(win == 5, "R4 R5 R6 itrig2 one tick per edge", win, 5);
    check(consec == 0, "R9 ticks single-cycle", consec, 0);

    cur_req = "R5"; cfg(3'd1, 3'd3, 0);
    run(4); win = 0;
    itrig[3] = 1; run(2);
    check(win == 0, "R5 no tick before third edge", win, 0);
    run(1); check(win == 1, "R5 tick after third edge", win, 1);
    run(4); itrig[3] = 0; run(4);
    check(win == 1, "R5 level held gives one event", win, 1);

    cur_req = "R4"; cfg(3'd7, 3'd7, 1);
    run(4); win = 0; pulses(1, 4);
    check(win == 2, "R4 ext_trig_f div2", win, 2);
    cfg(3'd3, 3'd4, 2);
    run(4); win = 0; pulses(2, 6);
    check(win == 2, "R4 ch0_edge div3", win, 2);
    cfg(3'd2, 3'd5, 0);
    run(4); win = 0; pulses(3, 4);
    check(win == 0, "R4 sel5 no source", win, 0);

    cur_req = "R9"; cfg(3'd0, 3'd0, 0);
    run(10);
    check(win == 10, "R9 R6 psc0 every cycle", win, 10);

    cur_req = "R7"; cfg(3'd0, 3'd0, 3);
    psc_val = 16'd7;
    run(40); check(win == 10, "R7 shadow not applied", win, 10);
    cfg(3'd0, 3'd0, 7);
    run(40); check(win == 5, "R7 applied after update", win, 5);
    run(3); update = 1; psc_val = 16'd1; step(); update = 0;
    run(20);

    cur_req = "R8"; cnt_en = 0; win = 0;
    run(20); check(win == 0, "R8 disabled no ticks", win, 0);
    cnt_en = 1; run(1);
    check(win == 0, "R8 count restarts from zero", win, 0);
    run(1); check(win == 1, "R8 first tick after re-enable", win, 1);
    run(5);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule